// File: doc/BRIEF.md
# Voltage Vector Limiter with Iterative Square Root

This block bounds a two-axis voltage command so that the vector stays inside the voltage an inverter can produce. A command pair (direct and quadrature components, signed) is presented with a one-cycle start strobe. The direct component is saturated first, to plus or minus full scale. The quadrature component is then limited by the largest value that keeps the vector length at or below full scale. That bound is the square root of full scale squared minus the saturated direct component squared, and it is recomputed for every command.

The square root is found at run time by a fixed number of Newton steps from a fixed starting guess. Each step needs one division, which an internal bit-serial restoring divider performs. The limited pair appears on the outputs together with a one-cycle done strobe. The outputs then hold until the next result. A command arrives, roughly two hundred and fifty cycles pass, and the result comes back. While that work is in progress the block accepts no new command.

Top module: `vector_limiter`

## Requirements
- R1: While reset is asserted and after it is released, `vd_out` and `vq_out` read zero and `done` is low until the first result.
- R2: The direct output equals `vd_cmd` (16-bit two's complement) saturated to the range -16383..+16383. A command of -32768 gives -16383.
- R3: The quadrature bound is computed from a = 16383*16383 - d*d, where d is the saturated direct value. The bound starts at x = 500 and takes exactly 8 integer steps x = floor((x + floor(a/x)) / 2).
- R4: When |vq_cmd| is at or below the bound, `vq_out` equals `vq_cmd`. Otherwise `vq_out` is the bound, carrying the sign of `vq_cmd`.
- R5: When a is zero (saturated |d| equals 16383), the bound is zero and `vq_out` is zero. No division takes place.
- R6: `done` is high for exactly one cycle per accepted command, in the cycle the new outputs first appear. The outputs keep their values in every cycle without `done`.
- R7: A start strobe that arrives while a command is being processed is ignored. It produces no extra `done` and does not change the result of the command in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle command strobe |
| vd_cmd | input | 16 | Direct-axis command, signed |
| vq_cmd | input | 16 | Quadrature-axis command, signed |
| vd_out | output | 16 | Limited direct-axis value, signed |
| vq_out | output | 16 | Limited quadrature-axis value, signed |
| done | output | 1 | One-cycle strobe marking new outputs |

## Verification
The hardest case to reach from the ports is a second start arriving while the square root is in progress. Without it, the busy guard is never exercised. The stimulus issues a command and, twenty cycles later (deep inside the Newton iterations), pulses start again with very different values. It then checks three things: that exactly one result appears, that the result matches the first command, and that no further done follows over a window longer than a full computation. The zero-radicand path is reached by driving the direct command to the saturation edge and beyond it, including the most negative code. The smallest nonzero radicand, 32765, is reached with a direct command of 16382.

// File: rtl/vlim_pkg.sv
package vlim_pkg;

  // Newton square-root sequencer states
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_LAUNCH = 2'd1,
    SQ_WAIT   = 2'd2,
    SQ_FIN    = 2'd3
  } sq_state_t;

endpackage

// File: rtl/vlim_div.sv
// Bit-serial restoring divider: one quotient bit per cycle.
module vlim_div #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);

  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          run_q, run_d;
  logic          done_q, done_d;

  logic [W:0]    shifted;
  logic [W:0]    trial;
  logic          fits;

  always_comb begin
    shifted = {rem_q[W-1:0], quo_q[W-1]};
    trial   = shifted - {1'b0, divisor};
    fits    = (shifted >= {1'b0, divisor});

    rem_d  = rem_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    run_d  = run_q;
    done_d = 1'b0;

    if (go) begin
      rem_d = '0;
      quo_d = dividend;
      cnt_d = CW'(W);
      run_d = 1'b1;
    end else if (run_q) begin
      rem_d = fits ? trial : shifted;
      quo_d = {quo_q[W-2:0], fits};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done     = done_q;
  assign quotient = quo_q;

endmodule

// File: rtl/vlim_sqrt.sv
// Fixed-count Newton square root using the serial divider.
module vlim_sqrt
  import vlim_pkg::*;
#(
  parameter int RW    = 28,
  parameter int GUESS = 500,
  parameter int ITERS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [RW-1:0] radicand,
  output logic          busy,
  output logic          root_valid,
  output logic [RW-1:0] root
);

  localparam int IW = $clog2(ITERS + 1);

  sq_state_t     st_q, st_d;
  logic [RW-1:0] a_q, a_d;
  logic [RW-1:0] x_q, x_d;
  logic [IW-1:0] it_q, it_d;

  logic          div_go;
  logic          div_done;
  logic [RW-1:0] quot;
  logic [RW:0]   sum;

  vlim_div #(.W(RW)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (a_q),
    .divisor  (x_q),
    .done     (div_done),
    .quotient (quot)
  );

  always_comb begin
    sum    = {1'b0, x_q} + {1'b0, quot};
    st_d   = st_q;
    a_d    = a_q;
    x_d    = x_q;
    it_d   = it_q;
    div_go = 1'b0;

    unique case (st_q)
      SQ_IDLE: begin
        if (go) begin
          a_d  = radicand;
          it_d = '0;
          if (radicand == '0) begin
            x_d  = '0;
            st_d = SQ_FIN;
          end else begin
            x_d  = RW'(GUESS);
            st_d = SQ_LAUNCH;
          end
        end
      end
      SQ_LAUNCH: begin
        div_go = 1'b1;
        st_d   = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (div_done) begin
          x_d  = sum[RW:1];
          it_d = it_q + 1'b1;
          st_d = (it_q == IW'(ITERS - 1)) ? SQ_FIN : SQ_LAUNCH;
        end
      end
      SQ_FIN: begin
        st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
      a_q  <= '0;
      x_q  <= '0;
      it_q <= '0;
    end else begin
      st_q <= st_d;
      a_q  <= a_d;
      x_q  <= x_d;
      it_q <= it_d;
    end
  end

  assign busy       = (st_q != SQ_IDLE);
  assign root_valid = (st_q == SQ_FIN);
  assign root       = x_q;

endmodule

// File: rtl/vlim_sat.sv
// Symmetric saturation of a signed value to +/- an unsigned bound.
module vlim_sat #(
  parameter int DW = 16,
  parameter int LW = 16
) (
  input  logic signed [DW-1:0] val,
  input  logic        [LW-1:0] lim,
  output logic signed [DW-1:0] res
);

  localparam int CW = (LW > DW + 1) ? LW : DW + 1;

  logic signed [DW:0]   ext;
  logic signed [DW:0]   neg;
  logic        [CW-1:0] mag;
  logic        [CW-1:0] limw;
  logic signed [DW-1:0] lim_s;

  always_comb begin
    ext   = {val[DW-1], val};
    neg   = -ext;
    mag   = CW'(unsigned'(ext[DW] ? neg : ext));
    limw  = CW'(lim);
    lim_s = $signed(DW'(lim));
    if (mag > limw) res = val[DW-1] ? -lim_s : lim_s;
    else            res = val;
  end

endmodule

// File: rtl/vector_limiter.sv
module vector_limiter #(
  parameter int DW    = 16,
  parameter int FS    = 16383,
  parameter int GUESS = 500,
  parameter int ITERS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic signed [DW-1:0] vd_cmd,
  input  logic signed [DW-1:0] vq_cmd,
  output logic signed [DW-1:0] vd_out,
  output logic signed [DW-1:0] vq_out,
  output logic                 done
);

  localparam int            MW    = $clog2(FS + 1);
  localparam int            RW    = 2 * MW;
  localparam logic [RW-1:0] FS_SQ = RW'(FS * FS);

  logic signed [DW-1:0] d_sat;
  logic        [DW-1:0] d_mag;
  logic        [RW-1:0] d_sq;
  logic        [RW-1:0] radicand;
  logic signed [DW-1:0] q_sat;

  logic                 sq_busy;
  logic                 sq_root_valid;
  logic        [RW-1:0] sq_root;
  logic                 accept;

  logic signed [DW-1:0] d_q, d_d;
  logic signed [DW-1:0] qc_q, qc_d;
  logic signed [DW-1:0] vd_q, vd_d;
  logic signed [DW-1:0] vq_q, vq_d;
  logic                 done_q, done_d;

  vlim_sat #(.DW(DW), .LW(DW)) u_dsat (
    .val (vd_cmd),
    .lim (DW'(FS)),
    .res (d_sat)
  );

  always_comb begin
    d_mag    = d_sat[DW-1] ? DW'(-d_sat) : DW'(d_sat);
    d_sq     = RW'(d_mag) * RW'(d_mag);
    radicand = FS_SQ - d_sq;
    accept   = start && !sq_busy;
  end

  vlim_sqrt #(.RW(RW), .GUESS(GUESS), .ITERS(ITERS)) u_sqrt (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (accept),
    .radicand   (radicand),
    .busy       (sq_busy),
    .root_valid (sq_root_valid),
    .root       (sq_root)
  );

  vlim_sat #(.DW(DW), .LW(RW)) u_qsat (
    .val (qc_q),
    .lim (sq_root),
    .res (q_sat)
  );

  always_comb begin
    d_d    = d_q;
    qc_d   = qc_q;
    vd_d   = vd_q;
    vq_d   = vq_q;
    done_d = 1'b0;
    if (accept) begin
      d_d  = d_sat;
      qc_d = vq_cmd;
    end
    if (sq_root_valid) begin
      vd_d   = d_q;
      vq_d   = q_sat;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q    <= '0;
      qc_q   <= '0;
      vd_q   <= '0;
      vq_q   <= '0;
      done_q <= 1'b0;
    end else begin
      d_q    <= d_d;
      qc_q   <= qc_d;
      vd_q   <= vd_d;
      vq_q   <= vq_d;
      done_q <= done_d;
    end
  end

  assign vd_out = vd_q;
  assign vq_out = vq_q;
  assign done   = done_q;

endmodule

// File: rtl/vlim_chk.sv
module vlim_chk #(
  parameter int DW = 16,
  parameter int RW = 28,
  parameter int FS = 16383
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 done,
  input logic signed [DW-1:0] vd_out,
  input logic signed [DW-1:0] vq_out,
  input logic                 sq_root_valid,
  input logic        [RW-1:0] sq_root
);

  logic [DW:0] q_mag;
  always_comb q_mag = vq_out[DW-1] ? (DW+1)'(-{vq_out[DW-1], vq_out})
                                   : (DW+1)'({1'b0, vq_out});

  // R6: strobe lasts a single cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: outputs hold between results
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(vd_out) && $stable(vq_out)));

  // R2: direct output within full scale
  assert_d_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (vd_out <= DW'(FS) && vd_out >= -DW'(FS)));

  // R4: quadrature output never exceeds the bound just computed
  assert_q_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sq_root_valid |=> ({{(RW-DW-1){1'b0}}, q_mag} <= $past(sq_root)));

  // R5: zero bound forces zero quadrature output
  assert_zero_root_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_root_valid && sq_root == '0) |=> (vq_out == '0));

endmodule

bind vector_limiter vlim_chk #(.DW(DW), .RW(RW), .FS(FS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .done          (done),
  .vd_out        (vd_out),
  .vq_out        (vq_out),
  .sq_root_valid (sq_root_valid),
  .sq_root       (sq_root)
);

// File: tb/sim_vector_limiter.sv
module sim_vector_limiter;

  logic               clk;
  logic               rst_n;
  logic               start;
  logic signed [15:0] vd_cmd;
  logic signed [15:0] vq_cmd;
  logic signed [15:0] vd_out;
  logic signed [15:0] vq_out;
  logic               done;

  int tests;
  int fails;
  int done_cnt;
  int exp_d_q[$];
  int exp_q_q[$];
  string tag_q[$];
  int last_d;
  int last_q;

  vector_limiter u0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .vd_cmd (vd_cmd),
    .vq_cmd (vq_cmd),
    .vd_out (vd_out),
    .vq_out (vq_out),
    .done   (done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int sat_d(int d);
    if (d > 16383) return 16383;
    if (d < -16383) return -16383;
    return d;
  endfunction

  // R3 bound model
  function automatic longint bound(int d);
    longint a;
    longint x;
    a = 64'd16383 * 64'd16383 - longint'(d) * longint'(d);
    if (a == 0) return 0;
    x = 500;
    for (int i = 0; i < 8; i++) x = (x + a / x) / 2;
    return x;
  endfunction

  function automatic int lim_q(int q, longint b);
    longint m;
    m = (q < 0) ? -q : q;
    if (m <= b) return q;
    return (q < 0) ? -int'(b) : int'(b);
  endfunction

  // Monitor: compares each result against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      tests++;
      if (exp_d_q.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected done: got d=%0d q=%0d expected none", vd_out, vq_out);
      end else begin
        int ed, eq;
        string t;
        ed = exp_d_q.pop_front();
        eq = exp_q_q.pop_front();
        t  = tag_q.pop_front();
        last_d = ed;
        last_q = eq;
        if (int'(vd_out) != ed || int'(vq_out) != eq) begin
          fails++;
          $display("FAIL %s result: got d=%0d q=%0d expected d=%0d q=%0d",
                   t, vd_out, vq_out, ed, eq);
        end
      end
      done_cnt++;
    end
  end

  task automatic strobe(int d, int q);
    @(negedge clk);
    vd_cmd = 16'(d);
    vq_cmd = 16'(q);
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
  endtask

  task automatic push(int d, int q, string t);
    int sd;
    sd = sat_d(d);
    exp_d_q.push_back(sd);
    exp_q_q.push_back(lim_q(q, bound(sd)));
    tag_q.push_back(t);
  endtask

  task automatic run(int d, int q, string t);
    int c;
    c = done_cnt;
    push(d, q, t);
    strobe(d, q);
    while (done_cnt == c) @(negedge clk);
    repeat (4) @(negedge clk);
    tests++;
    if (done !== 1'b0 || int'(vd_out) != last_d || int'(vq_out) != last_q) begin
      fails++;
      $display("FAIL R6 hold: got d=%0d q=%0d done=%0b expected d=%0d q=%0d done=0",
               vd_out, vq_out, done, last_d, last_q);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; done_cnt = 0;
    start = 1'b0; vd_cmd = '0; vq_cmd = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    tests++;
    if (vd_out !== 16'sd0 || vq_out !== 16'sd0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R1 in reset: got d=%0d q=%0d done=%0b expected 0 0 0", vd_out, vq_out, done);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    tests++;
    if (vd_out !== 16'sd0 || vq_out !== 16'sd0 || done !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset: got d=%0d q=%0d done=%0b expected 0 0 0", vd_out, vq_out, done);
    end

    run(0, 0, "R3");
    run(0, 20000, "R4");
    run(0, -32768, "R4");
    run(10000, 5000, "R4");
    run(-12000, -15000, "R4");
    run(100, 16383, "R3");
    run(5, -3, "R3");
    run(16382, 300, "R3");          // smallest nonzero radicand 32765
    run(16382, -300, "R3");
    run(16383, 1000, "R5");
    run(-32768, -500, "R2");
    run(20000, 7, "R2");
    run(-16384, 12345, "R5");

    // R7: second strobe during the computation must be ignored
    begin
      int c;
      c = done_cnt;
      push(3000, -7000, "R7");
      strobe(3000, -7000);
      repeat (20) @(negedge clk);
      strobe(-100, 9999);
      while (done_cnt == c) @(negedge clk);
      repeat (400) @(negedge clk);
      tests++;
      if (done_cnt != c + 1) begin
        fails++;
        $display("FAIL R7 done count: got %0d expected %0d", done_cnt - c, 1);
      end
      tests++;
      if (int'(vd_out) != sat_d(3000) || int'(vq_out) != lim_q(-7000, bound(3000))) begin
        fails++;
        $display("FAIL R7 result kept: got d=%0d q=%0d expected d=%0d q=%0d",
                 vd_out, vq_out, sat_d(3000), lim_q(-7000, bound(3000)));
      end
    end

    run(-8000, 16000, "R4");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule